// File: doc/BRIEF.md
# Random Number Peripheral Register Interface

This block is a memory-mapped random number source seen through a 32-bit register bus. It has three registers: control, status and data. While generation is enabled, an internal 32-bit LFSR stands in for a physical entropy source. The block delivers one word every fixed number of cycles into a four-word buffer. Once the buffer is full, the block raises a ready flag. Software may then read the data register four times in a row without polling between reads.

Two fault paths are visible to software. A seed-fault input reports a bad entropy source. It is mirrored live in the status register and also sets a sticky flag. It discards whatever the buffer holds and keeps ready low until the fault is gone and four fresh words have been gathered. Software recovers by clearing the sticky flag, throwing away twelve data reads and checking the flag again. A clock-fault input sets a second sticky flag, unless software has turned clock-fault detection off in the control register.

Top module: `rng_regif_top`

## Requirements
- R1: Register offsets are 0x0 for control, 0x4 for status and 0x8 for data. Control keeps only bit 2 (generation enable) and bit 5 (set to turn clock-fault detection off). Every other control bit reads zero, and a read of any other offset returns zero.
- R2: Words are produced in a fixed order. The first is the SEED parameter (default 0xACE12468). Each later word x' is computed from the previous word x as (x >> 1) XOR (x[0] ? 0x80200003 : 0). No word is skipped or repeated, except the words lost to a seed-fault flush.
- R3: While enabled and not full, the generator stores one word every 8 cycles. After the edge that samples the enabling write, a status read sampled 31 edges later shows ready (bit 0) clear. A status read sampled 33 edges later shows it set.
- R4: Ready stays set through the first three data reads and clears at the edge that takes the fourth. The buffer then refills with the same 8-cycle spacing as in R3.
- R5: A data read while ready is clear returns zero and does not consume a word.
- R6: Writing zero to control stops generation, so ready never rises. Words already stored are kept, and after re-enabling the sequence continues without a gap.
- R7: Status bit 2 follows the seed-fault input one cycle late, and while it is set, sticky bit 6 is set. The fault empties the buffer, so ready clears and stays clear for as long as the fault lasts.
- R8: A status write clears bit 5 or bit 6 where the written bit is zero and leaves it unchanged where the written bit is one. It never changes bits 0 or 2. A flag whose cause is still present stays set despite a clearing write.
- R9: After the fault is removed and bit 6 is cleared, twelve discard reads return zero and bit 6 stays clear. The next burst then holds the four words that follow the flushed ones. If the fault persists, bit 6 reads set again after the discard reads.
- R10: A clock-fault input pulse sets sticky status bit 5 unless control bit 5 is set.
- R11: A synchronous active-high reset clears control, status, buffer and read data.
- R12: bus_rdata takes the addressed value at the clock edge that samples bus_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| seed_fault | input | 1 | Entropy source fault indication |
| clk_fault | input | 1 | Clock fault indication |

## Verification
Read data is due one edge after the read is sampled, and both fault inputs reach the status register one edge after they change. Sticky flags and the buffer flush therefore show two edges after a fault is applied. The bench drives every strobe half a cycle before the edge that samples it and reads bus_rdata half a cycle after. It places status reads at exact edge counts after the enabling write and after the fourth data read, so the 32-cycle fill time is pinned from both sides. Word values are checked against an LFSR model in the bench. That model advances only on words the buffer accepted, and the bench applies faults only while the buffer is full so that the flushed words are known.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int CTRL_EN_BIT     = 2;
  localparam int CTRL_CEDOFF_BIT = 5;
  localparam int ST_RDY_BIT      = 0;
  localparam int ST_SEEDNOW_BIT  = 2;
  localparam int ST_CLKSTK_BIT   = 5;
  localparam int ST_SEEDSTK_BIT  = 6;

  typedef struct packed {
    logic ced_off;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rng_word_src.sv
module rng_word_src #(
  parameter int          DATA_W = 32,
  parameter int          PERIOD = 8,
  parameter logic [31:0] SEED   = 32'hACE1_2468,
  parameter logic [31:0] TAPS   = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic              word_vld,
  output logic [DATA_W-1:0] word
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] lfsr_nxt;

  assign word_vld = run && (cnt_q == CW'(PERIOD - 1));
  assign word     = lfsr_q;
  assign lfsr_nxt = {1'b0, lfsr_q[DATA_W-1:1]} ^ (lfsr_q[0] ? TAPS[DATA_W-1:0] : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lfsr_q <= SEED[DATA_W-1:0];
    end else begin
      if (!run)          cnt_q <= '0;
      else if (word_vld) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
      if (word_vld) lfsr_q <= lfsr_nxt;
    end
  end

  // R2
  spacing_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> (word != $past(word)));
  // R2
  nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

// File: rtl/rng_word_buf.sv
module rng_word_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic              ready,
  output logic [DATA_W-1:0] rd_word
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int RW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr_q;
  logic [RW-1:0]     rptr_q;
  logic              take;
  logic              last_pop;

  assign ready    = (wptr_q == PW'(DEPTH));
  assign take     = wr_en && !ready;
  assign last_pop = ready && pop && (rptr_q == RW'(DEPTH - 1));
  assign rd_word  = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (take) mem[wptr_q[RW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (last_pop) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (ready && pop) begin
      rptr_q <= rptr_q + 1'b1;
    end else if (take) begin
      wptr_q <= wptr_q + 1'b1;
    end
  end

  // R7
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ready);
  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !pop && !flush) |=> ready);
  // R4
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !wr_en);
endmodule

// File: rtl/rng_flags.sv
module rng_flags (
  input  logic clk,
  input  logic rst,
  input  logic seed_fault,
  input  logic clk_fault,
  input  logic ced_off,
  input  logic st_wr,
  input  logic wd_clk,
  input  logic wd_seed,
  output logic seed_now,
  output logic seed_stk,
  output logic clk_stk
);
  logic clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_now <= 1'b0;
      clk_q    <= 1'b0;
      seed_stk <= 1'b0;
      clk_stk  <= 1'b0;
    end else begin
      seed_now <= seed_fault;
      clk_q    <= clk_fault;
      if (seed_now)              seed_stk <= 1'b1;
      else if (st_wr && !wd_seed) seed_stk <= 1'b0;
      if (clk_q && !ced_off)     clk_stk <= 1'b1;
      else if (st_wr && !wd_clk) clk_stk <= 1'b0;
    end
  end

  // R7
  seed_set_chk: assert property (@(posedge clk) disable iff (rst)
    seed_now |=> seed_stk);
  // R10
  clk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_q && !ced_off) |=> clk_stk);
  // R8
  keep_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_stk && st_wr && wd_seed) |=> seed_stk);
endmodule

// File: rtl/rng_regif_top.sv
module rng_regif_top #(
  parameter int          ADDR_W = 4,
  parameter int          PERIOD = 8,
  parameter int          DEPTH  = 4,
  parameter logic [31:0] SEED   = 32'hACE1_2468,
  parameter logic [31:0] TAPS   = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seed_fault,
  input  logic              clk_fault
);
  import rng_pkg::*;

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8);

  ctrl_t       ctrl_q;
  logic        run;
  logic        word_vld;
  logic [31:0] word;
  logic        buf_ready;
  logic [31:0] buf_word;
  logic        pop;
  logic        seed_now, seed_stk, clk_stk;
  logic        st_wr;
  logic [31:0] ctrl_word, stat_word;
  logic        unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata};
  assign run   = ctrl_q.en && !seed_now && !buf_ready;
  assign pop   = bus_rd && (bus_addr == OFF_DATA) && buf_ready;
  assign st_wr = bus_wr && (bus_addr == OFF_STAT);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]     = ctrl_q.en;
    ctrl_word[CTRL_CEDOFF_BIT] = ctrl_q.ced_off;
    stat_word = '0;
    stat_word[ST_RDY_BIT]      = buf_ready;
    stat_word[ST_SEEDNOW_BIT]  = seed_now;
    stat_word[ST_CLKSTK_BIT]   = clk_stk;
    stat_word[ST_SEEDSTK_BIT]  = seed_stk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (bus_wr && (bus_addr == OFF_CTRL)) begin
      ctrl_q.en      <= bus_wdata[CTRL_EN_BIT];
      ctrl_q.ced_off <= bus_wdata[CTRL_CEDOFF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_CTRL: bus_rdata <= ctrl_word;
        OFF_STAT: bus_rdata <= stat_word;
        OFF_DATA: bus_rdata <= buf_ready ? buf_word : '0;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  rng_word_src #(.DATA_W(32), .PERIOD(PERIOD), .SEED(SEED), .TAPS(TAPS)) u_src (
    .clk(clk), .rst(rst), .run(run), .word_vld(word_vld), .word(word)
  );

  rng_word_buf #(.DATA_W(32), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush(seed_now), .wr_en(word_vld), .wr_data(word),
    .pop(pop), .ready(buf_ready), .rd_word(buf_word)
  );

  rng_flags u_flags (
    .clk(clk), .rst(rst), .seed_fault(seed_fault), .clk_fault(clk_fault),
    .ced_off(ctrl_q.ced_off), .st_wr(st_wr),
    .wd_clk(bus_wdata[ST_CLKSTK_BIT]), .wd_seed(bus_wdata[ST_SEEDSTK_BIT]),
    .seed_now(seed_now), .seed_stk(seed_stk), .clk_stk(clk_stk)
  );

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFF_DATA) && !buf_ready) |=> (bus_rdata == '0));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/rng_regif_top_tb.sv
module rng_regif_top_tb;
  localparam logic [31:0] TB_SEED = 32'hACE1_2468;
  localparam logic [31:0] TB_TAPS = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        seed_fault = 1'b0, clk_fault = 1'b0;

  int n_cmp = 0;
  int n_err = 0;
  logic [31:0] exp_lfsr = TB_SEED;

  always #5 clk = ~clk;

  rng_regif_top #(.ADDR_W(4), .PERIOD(8), .DEPTH(4), .SEED(TB_SEED), .TAPS(TB_TAPS)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seed_fault(seed_fault), .clk_fault(clk_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return (x >> 1) ^ (x[0] ? TB_TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] take_exp();
    logic [31:0] w;
    w = exp_lfsr;
    exp_lfsr = nxt(exp_lfsr);
    return w;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_ready(input string req);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(4'h4, s);
      if (s[0]) return;
    end
    chk(req, 32'h0, 32'h1);
  endtask

  task automatic read_burst(input string req);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(4'h8, d);
      chk(req, d, take_exp());
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state, R1 unmapped offset
    rd(4'h0, d); chk("R11 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R11 status", d, 32'h0);
    rd(4'h8, d); chk("R5 data empty", d, 32'h0);
    rd(4'hC, d); chk("R1 unmapped", d, 32'h0);

    // R1 control keeps only bits 2 and 5
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R1 ctrl readback", d, 32'h24);
    rd(4'h0, d); chk("R12 rdata repeat", d, 32'h24);
    wr(4'h0, 32'h0);

    // R3 exact fill time
    wr(4'h0, 32'h4);
    idle(29);
    rd(4'h4, d); chk("R3 not yet ready", d, 32'h0);
    idle(0);
    @(posedge clk); @(negedge clk);
    rd(4'h4, d); chk("R3 ready", d, 32'h1);

    // R2 R4 R5 bursts
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 3; i++) begin
        rd(4'h8, d); chk("R2 word", d, take_exp());
      end
      rd(4'h4, d); chk("R4 ready held after three", d, 32'h1);
      rd(4'h8, d); chk("R2 fourth word", d, take_exp());
      rd(4'h4, d); chk("R4 ready dropped", d, 32'h0);
      rd(4'h8, d); chk("R5 read while not ready", d, 32'h0);
      idle(28);
      rd(4'h4, d); chk("R4 refill not yet", d, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(4'h4, d); chk("R4 refill ready", d, 32'h1);
    end
    read_burst("R5 no advance");

    // R6 stop keeps partial words
    idle(19);
    wr(4'h0, 32'h0);
    idle(60);
    rd(4'h4, d); chk("R6 stopped", d, 32'h0);
    wr(4'h0, 32'h4);
    wait_ready("R6 resume");
    // R8 writes leave bits 0 and 2 alone
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R8 ones write", d, 32'h1);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R8 zero write keeps ready", d, 32'h1);
    read_burst("R6 sequence continues");

    // R7 R9 seed fault with recovery
    wait_ready("R7 prefill");
    seed_fault = 1'b1;
    idle(2);
    rd(4'h4, d); chk("R7 fault status", d, 32'h44);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R8 set wins", d, 32'h44);
    idle(40);
    rd(4'h4, d); chk("R7 ready held low", d, 32'h44);
    for (int i = 0; i < 4; i++) void'(take_exp());
    seed_fault = 1'b0;
    idle(2);
    rd(4'h4, d); chk("R7 live bit clears", d, 32'h40);
    wr(4'h4, 32'h0);
    for (int i = 0; i < 12; i++) begin
      rd(4'h8, d); chk("R9 discard read", d, 32'h0);
    end
    rd(4'h4, d); chk("R9 flag stays clear", d & 32'h40, 32'h0);
    wait_ready("R9 refill");
    read_burst("R9 fresh words");

    // R9 persistent fault
    wait_ready("R9 prefill");
    seed_fault = 1'b1;
    idle(2);
    wr(4'h4, 32'h0);
    for (int i = 0; i < 12; i++) begin
      rd(4'h8, d); chk("R9 discard under fault", d, 32'h0);
    end
    rd(4'h4, d); chk("R9 fault returns", d, 32'h44);
    for (int i = 0; i < 4; i++) void'(take_exp());
    seed_fault = 1'b0;
    idle(2);
    wr(4'h4, 32'h0);
    wait_ready("R9 second refill");
    read_burst("R9 words after persistent");

    // R10 clock fault with detection on, then off
    clk_fault = 1'b1; idle(0); @(posedge clk); @(negedge clk); clk_fault = 1'b0;
    idle(2);
    rd(4'h4, d); chk("R10 clock flag set", d & 32'h20, 32'h20);
    wr(4'h4, 32'h20);
    rd(4'h4, d); chk("R8 one keeps clock flag", d & 32'h20, 32'h20);
    wr(4'h4, 32'h40);
    rd(4'h4, d); chk("R8 zero clears clock flag", d & 32'h20, 32'h0);
    wr(4'h0, 32'h24);
    clk_fault = 1'b1; @(posedge clk); @(negedge clk); clk_fault = 1'b0;
    idle(2);
    rd(4'h4, d); chk("R10 detection off", d & 32'h20, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule